// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular ring of 16-byte transmit descriptors held in system memory. Software programs the ring through a small register window: a base address split into low and high words, a ring length, a producer index and a consumer index, plus a control word that carries the enable bit. Software fills descriptors and then moves the producer index forward. The engine owns the consumer index and chases the producer.

For each pending slot the engine issues one read on a simple memory port and decodes the returned little-endian descriptor. When the descriptor is usable, the engine presents the frame's buffer address and length on a valid/ready request output to a downstream frame mover. When the mover pulses its done input, the engine moves the consumer index on by one and wraps it at the ring length. Software learns that every posted frame has gone by polling until the consumer index equals the producer index.

Top module: `txring_engine`

## Requirements
- R1: After reset every register in the window reads zero, and `mem_rd_valid` and `frm_valid` are low.
- R2: The register window sits at these offsets: control 0x00 (bit 31 enables the ring, other bits read zero), base low 0x10 (bits 6:0 are forced to zero, so the ring is 128-byte aligned), base high 0x14, producer index 0x18, consumer index 0x1C, ring length 0x20 (bits 2:0 are forced to zero, so the length is a multiple of 8). Index registers keep only bits 15:0 and read zero above them.
- R3: While enabled, the engine has at most one memory read or frame request outstanding. It reads the descriptor of slot `ci` at address `base + ci*16`.
- R4: The descriptor is decoded little-endian. Bits 63:0 are the buffer address, bits 79:64 the buffer length, bits 95:80 the frame length, bits 111:96 the error/checksum field and bits 127:112 the flags. Flag bit 15 (descriptor bit 127) marks the final fragment. The frame request carries the buffer address and the buffer length.
- R5: A frame request holds `frm_valid`, `frm_addr` and `frm_len` steady until `frm_ready` is seen high.
- R6: After `frm_done`, the consumer index advances by one. It wraps from length-1 to 0.
- R7: A descriptor whose buffer length is zero produces no frame request, and the consumer index still advances past it.
- R8: A descriptor without the final-fragment flag produces no frame request, and the consumer index still advances past it.
- R9: No descriptor is fetched while the ring is disabled. If the enable bit is cleared while a descriptor is in flight, that descriptor completes and then fetching stops.
- R10: A producer index write always loads. A consumer index write loads only while the ring is disabled, and has no effect while it is enabled.
- R11: The ring is empty when producer equals consumer, so a ring of length N holds at most N-1 posted descriptors. Posting N-1 descriptors gets all of them processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 64 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Descriptor contents |
| frm_valid | output | 1 | Frame request valid |
| frm_ready | input | 1 | Frame mover accepts the request |
| frm_addr | output | 64 | Frame buffer address |
| frm_len | output | 16 | Frame length in bytes |
| frm_done | input | 1 | Frame mover finished the frame |

## Verification
The bench goes after the wrap from the last slot to slot zero. A design that got it wrong would read past the ring or never reach slot zero, and the consumer index would stall. It also targets zero-length and non-final descriptors: mishandling them either sends a bogus frame request or leaves the consumer index stuck. The full ring is posted with N-1 descriptors, which exposes an off-by-one empty test. Two control cases close the list. Disabling mid-frame must complete the current slot and start nothing more. Consumer-index writes while enabled must not corrupt hardware ownership of the index.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_BASE_LO = 8'h10;
    localparam logic [7:0] OFS_BASE_HI = 8'h14;
    localparam logic [7:0] OFS_PROD    = 8'h18;
    localparam logic [7:0] OFS_CONS    = 8'h1C;
    localparam logic [7:0] OFS_LEN     = 8'h20;

    localparam int DESC_BYTES = 16;
    localparam int FINAL_BIT  = 15;

    // fixed descriptor layout, most significant field first
    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] err_csum;
        logic [15:0] frame_len;
        logic [15:0] buf_len;
        logic [63:0] buf_addr;
    } tx_desc_t;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FETCH,
        W_WAIT,
        W_SEND,
        W_DONE
    } walk_state_e;

endpackage

// File: rtl/txring_regs.sv
module txring_regs #(
    parameter int IDX_W  = 16,
    parameter int REG_AW = 8,
    parameter int DATA_W = 32,
    parameter int ALIGN_BITS = 7,
    parameter int LEN_GRAN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ci_adv,
    output logic              en,
    output logic [2*DATA_W-1:0] base,
    output logic [IDX_W-1:0]  pi,
    output logic [IDX_W-1:0]  ci,
    output logic [IDX_W-1:0]  len
);
    import txring_pkg::*;

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] base_lo;
        logic [DATA_W-1:0] base_hi;
        logic [IDX_W-1:0]  pi;
        logic [IDX_W-1:0]  ci;
        logic [IDX_W-1:0]  len;
    } regs_t;

    regs_t r_d, r_q;

    localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'((1 << ALIGN_BITS) - 1);
    localparam logic [IDX_W-1:0]  LEN_MASK  = ~IDX_W'((1 << LEN_GRAN_BITS) - 1);

    logic [IDX_W-1:0] ci_inc;

    always_comb begin
        r_d    = r_q;
        ci_inc = r_q.ci + 1'b1;
        if (wr_en) begin
            unique case (wr_addr)
                OFS_CTRL:    r_d.en      = wr_data[DATA_W-1];
                OFS_BASE_LO: r_d.base_lo = wr_data & BASE_MASK;
                OFS_BASE_HI: r_d.base_hi = wr_data;
                OFS_PROD:    r_d.pi      = wr_data[IDX_W-1:0];
                OFS_CONS:    if (!r_q.en) r_d.ci = wr_data[IDX_W-1:0];
                OFS_LEN:     r_d.len     = wr_data[IDX_W-1:0] & LEN_MASK;
                default: ;
            endcase
        end
        // hardware advance wins over any software consumer write
        if (ci_adv) begin
            r_d.ci = (ci_inc >= r_q.len) ? '0 : ci_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFS_CTRL:    rd_data[DATA_W-1]  = r_q.en;
            OFS_BASE_LO: rd_data            = r_q.base_lo;
            OFS_BASE_HI: rd_data            = r_q.base_hi;
            OFS_PROD:    rd_data[IDX_W-1:0] = r_q.pi;
            OFS_CONS:    rd_data[IDX_W-1:0] = r_q.ci;
            OFS_LEN:     rd_data[IDX_W-1:0] = r_q.len;
            default: ;
        endcase
    end

    assign en   = r_q.en;
    assign base = {r_q.base_hi, r_q.base_lo};
    assign pi   = r_q.pi;
    assign ci   = r_q.ci;
    assign len  = r_q.len;

    AST_CI_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_CONS && r_q.en && !ci_adv) |=> $stable(r_q.ci)); // R10
    AST_CI_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ci_adv && r_q.len != '0 && r_q.ci == r_q.len - 1'b1) |=> (r_q.ci == '0)); // R6

endmodule

// File: rtl/txring_walker.sv
module txring_walker #(
    parameter int IDX_W  = 16,
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16,
    parameter int DESC_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  pi,
    input  logic [IDX_W-1:0]  ci,
    input  logic [IDX_W-1:0]  len,
    output logic              ci_adv,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic [ADDR_W-1:0] frm_addr,
    output logic [LEN_W-1:0]  frm_len,
    input  logic              frm_done
);
    import txring_pkg::*;

    localparam int SLOT_SHIFT = $clog2(DESC_BYTES);

    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] fetch_addr;
        logic [ADDR_W-1:0] f_addr;
        logic [LEN_W-1:0]  f_len;
    } walk_t;

    walk_t w_d, w_q;
    tx_desc_t desc;

    always_comb begin
        w_d    = w_q;
        ci_adv = 1'b0;
        desc   = tx_desc_t'(mem_rsp_data);
        unique case (w_q.st)
            W_IDLE: begin
                if (en && len != '0 && ci != pi) begin
                    w_d.fetch_addr = base + (ADDR_W'(ci) << SLOT_SHIFT);
                    w_d.st         = W_FETCH;
                end
            end
            W_FETCH: begin
                if (mem_rd_ready) w_d.st = W_WAIT;
            end
            W_WAIT: begin
                if (mem_rsp_valid) begin
                    if (desc.buf_len == '0 || !desc.flags[FINAL_BIT]) begin
                        ci_adv = 1'b1;
                        w_d.st = W_IDLE;
                    end else begin
                        w_d.f_addr = desc.buf_addr;
                        w_d.f_len  = desc.buf_len;
                        w_d.st     = W_SEND;
                    end
                end
            end
            W_SEND: begin
                if (frm_ready) w_d.st = W_DONE;
            end
            W_DONE: begin
                if (frm_done) begin
                    ci_adv = 1'b1;
                    w_d.st = W_IDLE;
                end
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '{st: W_IDLE, default: '0};
        else        w_q <= w_d;
    end

    assign mem_rd_valid = (w_q.st == W_FETCH);
    assign mem_rd_addr  = w_q.fetch_addr;
    assign frm_valid    = (w_q.st == W_SEND);
    assign frm_addr     = w_q.f_addr;
    assign frm_len      = w_q.f_len;

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R3
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_valid && frm_valid)); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_addr) && $stable(frm_len))); // R5
    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_valid) |-> ($past(en) && $past(ci) != $past(pi))); // R9

endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
    parameter int IDX_W  = 16,
    parameter int REG_AW = 8,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int DESC_W = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [REG_AW-1:0]   reg_wr_addr,
    input  logic [DATA_W-1:0]   reg_wr_data,
    input  logic [REG_AW-1:0]   reg_rd_addr,
    output logic [DATA_W-1:0]   reg_rd_data,
    output logic                mem_rd_valid,
    input  logic                mem_rd_ready,
    output logic [2*DATA_W-1:0] mem_rd_addr,
    input  logic                mem_rsp_valid,
    input  logic [DESC_W-1:0]   mem_rsp_data,
    output logic                frm_valid,
    input  logic                frm_ready,
    output logic [2*DATA_W-1:0] frm_addr,
    output logic [LEN_W-1:0]    frm_len,
    input  logic                frm_done
);
    localparam int ADDR_W = 2 * DATA_W;

    logic              en, ci_adv;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  pi, ci, len;

    txring_regs #(.IDX_W(IDX_W), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .ci_adv(ci_adv), .en(en), .base(base), .pi(pi), .ci(ci), .len(len)
    );

    txring_walker #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DESC_W(DESC_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .en(en), .base(base), .pi(pi), .ci(ci), .len(len), .ci_adv(ci_adv),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_addr(frm_addr),
        .frm_len(frm_len), .frm_done(frm_done)
    );

endmodule

// File: tb/tb_txring_engine.sv
module tb_txring_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [7:0]   reg_wr_addr = '0;
    logic [31:0]  reg_wr_data = '0;
    logic [7:0]   reg_rd_addr = '0;
    logic [31:0]  reg_rd_data;
    logic         mem_rd_valid;
    logic         mem_rd_ready = 1'b1;
    logic [63:0]  mem_rd_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;
    logic         frm_valid;
    logic         frm_ready = 1'b1;
    logic [63:0]  frm_addr;
    logic [15:0]  frm_len;
    logic         frm_done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    txring_engine dut (.*);

    localparam logic [63:0] BASE = 64'h0000_0001_0000_2000;

    int n_checks = 0, n_fail = 0;
    logic [127:0] dmem [0:7];
    logic [63:0]  fetch_log [0:63];
    logic [63:0]  req_addr [0:63];
    logic [15:0]  req_len  [0:63];
    int fetch_n = 0, req_n = 0, hold_bad = 0;
    bit stall = 1'b0;
    int cyc = 0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory responder: one-cycle read latency
    initial begin
        forever begin
            @(posedge clk);
            cyc <= cyc + 1;
            mem_rsp_valid <= 1'b0;
            if (mem_rd_valid && mem_rd_ready) begin
                fetch_log[fetch_n] <= mem_rd_addr;
                fetch_n <= fetch_n + 1;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data <= dmem[mem_rd_addr[6:4]];
            end
        end
    end

    // frame sink with optional backpressure and a done pulse 3 cycles later
    initial begin
        int cnt = 0;
        logic        pv = 1'b0;
        logic [63:0] pa = '0;
        logic [15:0] pl = '0;
        forever begin
            @(posedge clk);
            if (pv && (!frm_valid || frm_addr !== pa || frm_len !== pl)) hold_bad <= hold_bad + 1;
            pv = frm_valid && !frm_ready;
            pa = frm_addr;
            pl = frm_len;
            frm_done <= 1'b0;
            if (cnt != 0) begin
                cnt = cnt - 1;
                if (cnt == 0) frm_done <= 1'b1;
            end
            if (frm_valid && frm_ready) begin
                req_addr[req_n] <= frm_addr;
                req_len[req_n]  <= frm_len;
                req_n <= req_n + 1;
                cnt = 3;
            end
            frm_ready <= !stall || (cyc % 4 == 3);
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    function automatic logic [127:0] mkd(logic [63:0] a, logic [15:0] l, logic [15:0] fl);
        return {fl, 16'h0, l, l, a};
    endfunction

    task automatic wait_ci(logic [15:0] target, string req);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(8'h1C, v);
            if (v[15:0] == target) break;
        end
        check(req, {48'h0, v[15:0]}, {48'h0, target});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a <= 8'h20; a += 4) begin
            rd(8'(a), v);
            check("R1 reg reset", {32'h0, v}, 64'h0);
        end
        check("R1 mem_rd_valid", {63'h0, mem_rd_valid}, 64'h0);
        check("R1 frm_valid", {63'h0, frm_valid}, 64'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h10, 32'h1234_5FFF); rd(8'h10, v); check("R2 base low align", {32'h0, v}, 64'h1234_5F80);
        wr(8'h20, 32'h0000_0013); rd(8'h20, v); check("R2 length granule", {32'h0, v}, 64'h10);
        wr(8'h18, 32'hABCD_1234); rd(8'h18, v); check("R2 index mask", {32'h0, v}, 64'h1234);
        wr(8'h18, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 control bit31", {32'h0, v}, 64'h8000_0000);
        wr(8'h1C, 32'h5); rd(8'h1C, v); check("R10 ci write ignored while enabled", {32'h0, v}, 64'h0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R11 empty ring idle", {63'h0, mem_rd_valid}, 64'h0);
        end
        wr(8'h00, 32'h0);
        wr(8'h1C, 32'h3); rd(8'h1C, v); check("R10 ci write while disabled", {32'h0, v}, 64'h3);
        wr(8'h1C, 32'h0);
        wr(8'h10, BASE[31:0]); wr(8'h14, BASE[63:32]); wr(8'h20, 32'h8);
    endtask

    task automatic t_basic();
        int f0 = fetch_n, r0 = req_n;
        for (int i = 0; i < 3; i++) dmem[i] = mkd(64'hA000 + 64'(i) * 64'h100, 16'(60 + i), 16'h8000);
        wr(8'h18, 32'h3);
        wr(8'h00, 32'h8000_0000);
        wait_ci(16'h3, "R6 ci after three frames");
        check("R3 fetch count", 64'(fetch_n - f0), 64'd3);
        check("R4 request count", 64'(req_n - r0), 64'd3);
        for (int i = 0; i < 3; i++) begin
            check("R3 fetch address", fetch_log[f0 + i], BASE + 64'(i) * 16);
            check("R4 frame address", req_addr[r0 + i], 64'hA000 + 64'(i) * 64'h100);
            check("R4 frame length", {48'h0, req_len[r0 + i]}, 64'(60 + i));
        end
    endtask

    task automatic t_wrap_skip();
        int r0 = req_n, f0 = fetch_n;
        int exp_slots [5] = '{3, 6, 7, 0, 1};
        for (int i = 0; i < 8; i++) dmem[i] = mkd(64'hB000 + 64'(i) * 64'h40, 16'(100 + i), 16'h8000);
        dmem[4] = mkd(64'hB100, 16'h0, 16'h8000);   // zero length
        dmem[5] = mkd(64'hB140, 16'd77, 16'h0001);  // not final
        wr(8'h18, 32'h2);                           // 7 posted = length-1
        wait_ci(16'h2, "R11 full ring drained, R6 wrap");
        check("R11 fetches for full ring", 64'(fetch_n - f0), 64'd7);
        check("R7 R8 requests after skips", 64'(req_n - r0), 64'd5);
        for (int i = 0; i < 5; i++) begin
            check("R7 R8 request order", req_addr[r0 + i], 64'hB000 + 64'(exp_slots[i]) * 64'h40);
            check("R4 length per slot", {48'h0, req_len[r0 + i]}, 64'(100 + exp_slots[i]));
        end
    endtask

    task automatic t_stall();
        int r0 = req_n;
        stall = 1'b1;
        dmem[2] = mkd(64'hC000, 16'd500, 16'h8000);
        dmem[3] = mkd(64'hC800, 16'd501, 16'h8000);
        wr(8'h18, 32'h4);
        wait_ci(16'h4, "R6 ci under backpressure");
        stall = 1'b0;
        check("R5 request count under stall", 64'(req_n - r0), 64'd2);
        check("R5 address under stall", req_addr[r0 + 1], 64'hC800);
        check("R5 request held steady", 64'(hold_bad), 64'd0);
    endtask

    task automatic t_disable();
        int r0 = req_n;
        logic [31:0] v;
        dmem[4] = mkd(64'hD000, 16'd64, 16'h8000);
        dmem[5] = mkd(64'hD100, 16'd65, 16'h8000);
        wr(8'h18, 32'h6);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (frm_valid) break;
        end
        wr(8'h00, 32'h0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i > 10) check("R9 no fetch while disabled", {63'h0, mem_rd_valid}, 64'h0);
        end
        rd(8'h1C, v);
        check("R9 in-flight slot completed", {32'h0, v}, 64'h5);
        check("R9 one request then stop", 64'(req_n - r0), 64'd1);
        wr(8'h00, 32'h8000_0000);
        wait_ci(16'h6, "R9 resume after enable");
        check("R9 resumed request", req_addr[r0 + 1], 64'hD100);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) dmem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_wrap_skip();
        t_stall();
        t_disable();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule